// File: doc/BRIEF.md
# OTP Fuse Word Read Controller

This block lets a host read one 32-bit word at a time out of a one-time-programmable fuse array. The host sees a small bank of 32-bit registers: a control register that can be reached directly or through bit-set and bit-clear aliases, a timing register, a read-start register and a result register. Writing the start code begins a read of the fuse word named by the control address field. The controller then holds a relax gap and an enable pulse on the fuse port, with both lengths taken from the timing register, and captures the returned word.

A read that cannot be served returns the poison word 0xBADABADA instead of fuse data and raises a sticky error flag. This happens when the fuse port reports a failure, when a start arrives while the controller is busy, or when the error flag is still set. Software clears the flag through the clear alias. Programming, shadow reload and the program-strobe count are held in their register fields but drive nothing.

Top module: `otp_read_ctrl`

## Requirements
- R1: After reset the control register reads 0x00000000, the timing register reads 0x00052100, the result register reads 0x00000000, and the fuse enable is low.
- R2: Control is written whole at offset 0x00, ORed at offset 0x04 and cleared where ones are written at offset 0x08. Only bits [6:0] (word address), 9 (error), 10 (reload request) and [31:16] (key) are stored. Every other bit reads zero, and all three offsets read the control value.
- R3: Bit 8 of control is a read-only busy flag. It is 1 exactly while a read sequence runs, and writes to it have no effect.
- R4: The timing register at offset 0x10 stores bits [21:0]: program count [11:0], relax count [15:12] and strobe count [21:16]. Bits [31:22] read zero.
- R5: Writing 0x1 to offset 0x30 while idle with error clear keeps busy high for relax+strobe+3 cycles. The fuse enable is high for strobe+1 consecutive cycles, and the fuse address stays equal to control bits [6:0] throughout.
- R6: When fuse_fail is low, offset 0x40 then returns the fuse word that the port delivers in the cycle after the last enable cycle.
- R7: When fuse_fail is high at capture, the error flag is set and offset 0x40 returns 0xBADABADA.
- R8: A start while the error flag is set does not set busy or pulse the fuse enable. It loads 0xBADABADA into the result, and the error stays set until it is cleared through 0x08.
- R9: A start while busy sets the error flag and does not restart or lengthen the running read, and that read ends with 0xBADABADA.
- R10: A write of any value other than 0x1 to 0x30, and writes to 0x40 or to unmapped offsets, change nothing. Unmapped offsets read zero.
- R11: An error raised at capture wins over a host clear of bit 9 in the same cycle.
- R12: A read proceeds the same with the key field at 0x0000 or 0x3E77.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| fuse_addr | output | 7 | Fuse word address |
| fuse_rd_en | output | 1 | Fuse read enable |
| fuse_data | input | 32 | Fuse word, valid in the cycle after the last enable cycle |
| fuse_fail | input | 1 | Fuse read failure, sampled at capture |

## Verification
Two things can land on the error bit in one clock: the capture step raising it after a failed fuse read, and a host write through the clear alias. The bench follows the fuse enable until it drops, which marks the capture cycle, and issues the clear-alias write in that same cycle. It then expects the error flag to remain set and the result to hold the poison word. A later clear with no read running is expected to succeed, which shows that the survival of the flag came from the collision and not from a broken alias.

// File: rtl/otp_read_ctrl.sv
module otp_read_ctrl #(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned FUSE_AW    = 7,
  parameter logic [31:0] POISON     = 32'hBADA_BADA,
  parameter logic [31:0] TIMING_RST = 32'h0005_2100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [FUSE_AW-1:0] fuse_addr,
  output logic               fuse_rd_en,
  input  logic [31:0]        fuse_data,
  input  logic               fuse_fail
);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFF_SET  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFF_CLR  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFF_TIME = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFF_TRIG = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(8'h40);
  localparam int unsigned       ERR_BIT  = 9;
  localparam int unsigned       BUSY_BIT = 8;
  localparam logic [31:0] CTRL_MASK = 32'hFFFF_0000 | 32'h0000_0600 | ((32'd1 << FUSE_AW) - 32'd1);
  localparam logic [31:0] TIME_MASK = 32'h003F_FFFF;
  localparam int unsigned CNT_W = 6;

  typedef enum logic [1:0] {S_IDLE, S_RELAX, S_STROBE, S_LATCH} state_t;

  state_t             state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [31:0]        ctrl_q, ctrl_host, timing_q, rdata_q;
  logic [FUSE_AW-1:0] addr_q;

  wire busy       = (state_q != S_IDLE);
  wire err        = ctrl_q[ERR_BIT];
  wire trig       = bus_wr && (bus_addr == OFF_TRIG) && (bus_wdata == 32'd1);
  wire start      = trig && !busy && !err;
  wire trig_bad   = trig && (busy || err);
  wire latch_bad  = (state_q == S_LATCH) && (fuse_fail || err);
  wire hw_err_set = (trig && busy) || latch_bad;
  wire [CNT_W-1:0] relax_cnt  = CNT_W'(timing_q[15:12]);
  wire [CNT_W-1:0] strobe_cnt = timing_q[21:16];

  always_comb begin
    ctrl_host = ctrl_q;
    if (bus_wr) begin
      case (bus_addr)
        OFF_CTRL: ctrl_host = bus_wdata & CTRL_MASK;
        OFF_SET:  ctrl_host = ctrl_q | (bus_wdata & CTRL_MASK);
        OFF_CLR:  ctrl_host = ctrl_q & ~(bus_wdata & CTRL_MASK);
        default:  ctrl_host = ctrl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      timing_q <= TIMING_RST & TIME_MASK;
    end else begin
      ctrl_q <= ctrl_host | (hw_err_set ? (32'd1 << ERR_BIT) : 32'd0);
      if (bus_wr && bus_addr == OFF_TIME) timing_q <= bus_wdata & TIME_MASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          state_q <= S_RELAX;
          cnt_q   <= relax_cnt;
          addr_q  <= ctrl_q[FUSE_AW-1:0];
        end
        S_RELAX: if (cnt_q == '0) begin
          state_q <= S_STROBE;
          cnt_q   <= strobe_cnt;
        end else cnt_q <= cnt_q - 1'b1;
        S_STROBE: if (cnt_q == '0) state_q <= S_LATCH;
                  else cnt_q <= cnt_q - 1'b1;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       rdata_q <= '0;
    else if (trig_bad || latch_bad)   rdata_q <= POISON;
    else if (state_q == S_LATCH)      rdata_q <= fuse_data;
  end

  assign fuse_rd_en = (state_q == S_STROBE);
  assign fuse_addr  = addr_q;

  always_comb begin
    case (bus_addr)
      OFF_CTRL, OFF_SET, OFF_CLR: bus_rdata = ctrl_q | (32'(busy) << BUSY_BIT);
      OFF_TIME: bus_rdata = timing_q;
      OFF_DATA: bus_rdata = rdata_q;
      default:  bus_rdata = '0;
    endcase
  end

  assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !busy && !err) |=> bus_wr || (bus_rdata[BUSY_BIT] || bus_addr != OFF_CTRL) || busy);
  assert_addr_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_rd_en && $past(fuse_rd_en)) |-> $stable(fuse_addr));
  assert_idle_after_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fuse_rd_en) |=> !busy);
  assert_fail_poison_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_LATCH && fuse_fail) |=> (ctrl_q[ERR_BIT] && rdata_q == POISON));
  assert_err_trig_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !busy && err) |=> (!busy && !fuse_rd_en && rdata_q == POISON));
  assert_busy_trig_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && busy) |=> (ctrl_q[ERR_BIT] && rdata_q == POISON));
endmodule

// File: tb/otp_read_ctrl_tb_top.sv
module otp_read_ctrl_tb_top;
  localparam logic [31:0] POISON = 32'hBADA_BADA;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, fuse_fail = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, fuse_data = '0;
  logic [6:0] fuse_addr;
  logic fuse_rd_en;
  int checks = 0, errors = 0, rden_cnt = 0;
  bit done = 1'b0;

  typedef struct {
    string      req;
    int         busy_cyc;
    int         pulses;
    logic [31:0] data;
    logic        err;
  } item_t;
  item_t exp_q[$], act_q[$];

  always #10 clk = ~clk;

  otp_read_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fuse_addr(fuse_addr),
    .fuse_rd_en(fuse_rd_en), .fuse_data(fuse_data), .fuse_fail(fuse_fail));

  function automatic logic [31:0] fuse_word(input logic [6:0] a);
    return 32'hC300_0000 ^ {9'd0, a, 9'd0, a};
  endfunction

  always @(posedge clk) if (fuse_rd_en) fuse_data <= fuse_word(fuse_addr);
  always @(negedge clk) if (fuse_rd_en) rden_cnt <= rden_cnt + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    while (exp_q.size() > 0 && act_q.size() > 0) begin
      item_t e, a;
      e = exp_q.pop_front();
      a = act_q.pop_front();
      chk({e.req, " busy cycles"}, a.busy_cyc, e.busy_cyc);
      chk({e.req, " enable cycles"}, a.pulses, e.pulses);
      chk({e.req, " data"}, a.data, e.data);
      chk({e.req, " error flag"}, 32'(a.err), 32'(e.err));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic poll(output int n);
    logic [31:0] v;
    n = 0;
    forever begin
      rd(8'h00, v);
      if (!v[8]) break;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic do_read(input string req, input logic [6:0] a, input int rl, input int sr,
                         input logic fail, input logic [15:0] key);
    item_t e, r;
    int p0, n;
    logic [31:0] v;
    wr(8'h10, {10'd0, 6'(sr), 4'(rl), 12'h0AB});
    wr(8'h00, {key, 9'd0, a});
    fuse_fail = fail;
    p0 = rden_cnt;
    e.req = req; e.busy_cyc = rl + sr + 3; e.pulses = sr + 1;
    e.data = fail ? POISON : fuse_word(a); e.err = fail;
    exp_q.push_back(e);
    wr(8'h30, 32'd1);
    poll(n);
    rd(8'h40, v);
    r.req = req; r.busy_cyc = n; r.pulses = rden_cnt - p0; r.data = v;
    rd(8'h00, v);
    r.err = v[9];
    act_q.push_back(r);
    fuse_fail = 1'b0;
    @(negedge clk);
    if (fail) wr(8'h08, 32'h200);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n, p0;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(8'h00, v); chk("R1 ctrl reset", v, 32'h0);
    rd(8'h10, v); chk("R1 timing reset", v, 32'h0005_2100);
    rd(8'h40, v); chk("R1 data reset", v, 32'h0);
    chk("R1 enable low", 32'(fuse_rd_en), 32'h0);

    wr(8'h00, 32'h0000_0105);
    rd(8'h00, v); chk("R3 busy not writable", v, 32'h0000_0005);
    wr(8'h04, 32'h0000_F400);
    rd(8'h04, v); chk("R2 set alias", v, 32'h0000_0405);
    wr(8'h08, 32'h0000_0004);
    rd(8'h08, v); chk("R2 clear alias", v, 32'h0000_0401);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk("R2 stored bits", v, 32'hFFFF_067F);
    wr(8'h00, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, v); chk("R4 timing fields", v, 32'h003F_FFFF);

    do_read("R5 R6 nominal", 7'h21, 2, 5, 1'b0, 16'h0000);
    do_read("R5 R6 minimum", 7'h00, 0, 0, 1'b0, 16'h0000);
    do_read("R5 R6 maximum", 7'h7F, 15, 63, 1'b0, 16'h0000);
    do_read("R12 key set", 7'h3A, 1, 3, 1'b0, 16'h3E77);
    do_read("R7 fuse failure", 7'h05, 3, 2, 1'b1, 16'h0000);
    rd(8'h00, v); chk("R2 error cleared by alias", 32'(v[9]), 32'h0);

    wr(8'h04, 32'h200);
    p0 = rden_cnt;
    wr(8'h30, 32'd1);
    rd(8'h00, v); chk("R8 no busy on error", 32'(v[8]), 32'h0);
    repeat (4) @(negedge clk);
    chk("R8 no fuse enable", 32'(rden_cnt - p0), 32'h0);
    rd(8'h40, v); chk("R8 poison", v, POISON);
    rd(8'h00, v); chk("R8 error sticky", 32'(v[9]), 32'h1);
    wr(8'h08, 32'h200);
    rd(8'h00, v); chk("R8 error cleared", 32'(v[9]), 32'h0);

    do_read("R6 recovery", 7'h0F, 1, 1, 1'b0, 16'h0000);
    wr(8'h30, 32'd2);
    rd(8'h00, v); chk("R10 non-one start ignored", v, 32'h0000_000F);
    wr(8'h40, 32'h1234_5678);
    rd(8'h40, v); chk("R10 data not writable", v, fuse_word(7'h0F));
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, v); chk("R10 unmapped reads zero", v, 32'h0);
    rd(8'h00, v); chk("R10 unmapped write no effect", v, 32'h0000_000F);

    wr(8'h10, {10'd0, 6'd4, 4'd3, 12'h0});
    wr(8'h00, 32'h11);
    p0 = rden_cnt;
    wr(8'h30, 32'd1);
    wr(8'h30, 32'd1);
    poll(n);
    chk("R9 no restart", 32'(n + 1), 32'(3 + 4 + 3));
    chk("R9 enable cycles", 32'(rden_cnt - p0), 32'd5);
    rd(8'h40, v); chk("R9 poison", v, POISON);
    rd(8'h00, v); chk("R9 error set", 32'(v[9]), 32'h1);
    @(negedge clk);
    wr(8'h08, 32'h200);

    wr(8'h10, {10'd0, 6'd2, 4'd1, 12'h0});
    fuse_fail = 1'b1;
    wr(8'h30, 32'd1);
    seen = 1'b0;
    forever begin
      if (fuse_rd_en) seen = 1'b1;
      else if (seen) break;
      @(negedge clk);
    end
    wr(8'h08, 32'h200);
    fuse_fail = 1'b0;
    rd(8'h00, v); chk("R11 capture error beats clear", 32'(v[9]), 32'h1);
    rd(8'h40, v); chk("R11 poison", v, POISON);
    @(negedge clk);
    wr(8'h08, 32'h200);
    rd(8'h00, v); chk("R11 later clear works", 32'(v[9]), 32'h0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule